// File: doc/BRIEF.md
# Multiplier-Based 32-bit Left Shifter

This block shifts a 32-bit value left by a 16-bit count without a shift network. Small shift amounts are turned into a power-of-two factor taken from a table. One signed 16x16 multiplier then scales each 16-bit half of the value, one half per cycle. A correction adds terms to the upper half of the low-half product, so the signed product gives the same bits as an unsigned one. The high half's product only contributes its low 16 bits, and the signed and unsigned forms agree there anyway.

Counts of 32 or more give zero. Counts from 16 to 31 first move the low word into the high word and clear the low word, then shift by the count modulo 16. When that remaining amount is zero, the value goes straight to the output and the multiplier is not used. A caller pulses `start` with `value` and `count` and waits for the one-cycle `done` pulse, which marks a valid `result`.

Top module: `mul_lshift32`

## Requirements
- R1: A count of 32 or more gives a result of zero, with done asserted in the cycle after start is sampled.
- R2: For counts 16 to 31 the result equals the low word moved into the high half (low half zero) and then shifted by count modulo 16. In other words, the result is value shifted left by count, truncated to 32 bits.
- R3: When count modulo 16 is zero and count is below 32, the result is the (possibly word-moved) value, with done in the cycle after start is sampled and no multiply pass.
- R4: When count modulo 16 is nonzero and count is below 32, the result takes two multiply cycles, and done is asserted in the third cycle after start is sampled.
- R5: For counts 1 to 15, including 15 where the table factor 0x8000 is negative as a signed number, and for halves whose bit 15 is set, the result equals value shifted left by count, truncated to 32 bits.
- R6: done is high for exactly one cycle per accepted start.
- R7: A start pulse that arrives while a multiply is in progress is ignored. The result of the operation in flight is unchanged, and that start produces no extra done.
- R8: While reset is high, done is 0 and result is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request pulse, sampled when the block is idle |
| value | input | 32 | Data to be shifted |
| count | input | 16 | Left shift amount |
| result | output | 32 | Registered shifted value |
| done | output | 1 | One-cycle pulse marking result valid |

## Verification
The bench uses the default parameters: 16-bit halves and a 16-bit count, so the table holds 16 factors up to 0x8000. This lets every count from 0 to 40 be swept: the zero range, the word-move range, both pass-through points (0 and 16), and the negative factor at counts 15 and 31. Random values are mixed with values whose halves have bit 15 set, which drive both sign corrections, alone and together. Latency is checked for each of the two paths.

// File: rtl/lsh_pkg.sv
package lsh_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HI   = 2'd1,
    ST_LO   = 2'd2
  } lsh_state_e;
endpackage

// File: rtl/lsh_pow2_rom.sv
module lsh_pow2_rom #(
  parameter int W  = 16,
  parameter int KW = $clog2(W)
) (
  input  logic [KW-1:0] idx,
  output logic [W-1:0]  factor
);
  logic [W-1:0] tbl [W];

  generate
    for (genvar i = 0; i < W; i++) begin : g_entry
      assign tbl[i] = W'(1) << i;
    end
  endgenerate

  assign factor = tbl[idx];
endmodule

// File: rtl/lsh_smul.sv
module lsh_smul #(
  parameter int W = 16
) (
  input  logic signed [W-1:0]   a,
  input  logic signed [W-1:0]   b,
  output logic signed [2*W-1:0] p
);
  assign p = a * b;
endmodule

// File: rtl/lsh_sign_fix.sv
module lsh_sign_fix #(
  parameter int W = 16
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic [2*W-1:0] sprod,
  output logic [2*W-1:0] uprod
);
  logic [W-1:0] upper;

  always_comb begin
    upper = sprod[2*W-1:W];
    if (a[W-1]) upper = upper + b;
    if (b[W-1]) upper = upper + a;
    uprod = {upper, sprod[W-1:0]};
  end

  // R5: corrected signed product must equal the unsigned product
  always_comb begin
    if (!$isunknown({a, b, sprod}))
      a_r5_unsigned_match: assert (uprod == ({{W{1'b0}}, a} * {{W{1'b0}}, b}))
        else $error("a_r5_unsigned_match failed");
  end
endmodule

// File: rtl/mul_lshift32.sv
module mul_lshift32 #(
  parameter int WORD_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [2*WORD_W-1:0] value,
  input  logic [CNT_W-1:0]    count,
  output logic [2*WORD_W-1:0] result,
  output logic                done
);
  import lsh_pkg::*;

  localparam int DW = 2 * WORD_W;
  localparam int KW = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LIM_FAR  = CNT_W'(DW);
  localparam logic [CNT_W-1:0] LIM_MOVE = CNT_W'(WORD_W);

  lsh_state_e        state;
  logic [WORD_W-1:0] hi_w, lo_w, part_hi;
  logic [KW-1:0]     k;

  logic [WORD_W-1:0] hi_n, lo_n;
  logic              far, k_zero;

  always_comb begin
    far    = (count >= LIM_FAR);
    k_zero = (count[KW-1:0] == '0);
    if (count >= LIM_MOVE) begin
      hi_n = value[WORD_W-1:0];
      lo_n = '0;
    end else begin
      hi_n = value[DW-1:WORD_W];
      lo_n = value[WORD_W-1:0];
    end
  end

  logic [WORD_W-1:0] factor;
  logic [WORD_W-1:0] mul_a;
  logic [DW-1:0]     sprod, uprod;

  assign mul_a = (state == ST_LO) ? lo_w : hi_w;

  lsh_pow2_rom #(.W(WORD_W), .KW(KW)) u_rom (
    .idx   (k),
    .factor(factor)
  );

  lsh_smul #(.W(WORD_W)) u_mul (
    .a(mul_a),
    .b(factor),
    .p(sprod)
  );

  lsh_sign_fix #(.W(WORD_W)) u_fix (
    .a    (mul_a),
    .b    (factor),
    .sprod(sprod),
    .uprod(uprod)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      hi_w    <= '0;
      lo_w    <= '0;
      part_hi <= '0;
      k       <= '0;
      result  <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            if (far) begin
              result <= '0;
              done   <= 1'b1;
            end else if (k_zero) begin
              result <= {hi_n, lo_n};
              done   <= 1'b1;
            end else begin
              hi_w  <= hi_n;
              lo_w  <= lo_n;
              k     <= count[KW-1:0];
              state <= ST_HI;
            end
          end
        end
        ST_HI: begin
          part_hi <= uprod[WORD_W-1:0];
          state   <= ST_LO;
        end
        ST_LO: begin
          result <= {part_hi | uprod[DW-1:WORD_W], uprod[WORD_W-1:0]};
          done   <= 1'b1;
          state  <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R1: far counts yield zero after one cycle
  a_r1_far_zero: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && start && count >= LIM_FAR) |=> (done && result == '0))
    else $error("a_r1_far_zero failed");

  // R3: zero remainder passes through without the multiplier
  a_r3_bypass: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && start && count < LIM_FAR && count[KW-1:0] == '0)
      |=> (done && state == ST_IDLE &&
           result == (($past(count) >= LIM_MOVE) ?
                      {$past(value[WORD_W-1:0]), {WORD_W{1'b0}}} : $past(value))))
    else $error("a_r3_bypass failed");

  // R4: high-half pass is always followed by low-half pass, no done yet
  a_r4_hi_then_lo: assert property (@(posedge clk) disable iff (rst)
    (state == ST_HI) |=> (state == ST_LO && !done))
    else $error("a_r4_hi_then_lo failed");

  // R6: done only comes from an accepted start or the final pass
  a_r6_done_source: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(state) == ST_LO || ($past(state) == ST_IDLE && $past(start))))
    else $error("a_r6_done_source failed");

  // R7: operands are frozen while a multiply is in progress
  a_r7_busy_hold: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE) |=> ($stable(k) && $stable(lo_w) && $stable(hi_w)))
    else $error("a_r7_busy_hold failed");
endmodule

// File: tb/mul_lshift32_test.sv
module mul_lshift32_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] value = '0;
  logic [15:0] count = '0;
  logic [31:0] result;
  logic        done;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  mul_lshift32 uut (
    .clk(clk), .rst(rst), .start(start), .value(value),
    .count(count), .result(result), .done(done)
  );

  function automatic logic [31:0] exp_shift(input logic [31:0] v, input logic [15:0] c);
    if (c >= 16'd32) return 32'h0;
    return v << c[4:0];
  endfunction

  function automatic string req_of(input logic [15:0] c);
    if (c >= 16'd32) return "R1";
    if (c[3:0] == 4'd0) return "R3";
    if (c >= 16'd16) return "R2";
    return "R5";
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  // one operation; optionally injects a start while busy (R7)
  task automatic run_op(input logic [31:0] v, input logic [15:0] c, input bit poke);
    int lat;
    int explat;
    logic [31:0] expr;
    expr   = exp_shift(v, c);
    explat = (c >= 16'd32 || c[3:0] == 4'd0) ? 1 : 3;
    @(negedge clk);
    value = v; count = c; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    if (poke && !done) begin
      value = ~v; count = 16'd1; start = 1'b1;
    end
    while (!done && lat < 10) begin
      @(negedge clk);
      start = 1'b0;
      lat++;
    end
    start = 1'b0;
    check(done == 1'b1, explat == 1 ? "R3" : "R4", "done seen", 32'(done), 32'd1);
    check(lat == explat, explat == 1 ? "R1" : "R4", "latency", 32'(lat), 32'(explat));
    check(result == expr, poke ? "R7" : req_of(c), "result", result, expr);
    @(negedge clk);
    check(done == 1'b0, "R6", "done pulse width", 32'(done), 32'd0);
    if (poke) begin
      repeat (3) begin
        @(negedge clk);
        check(done == 1'b0, "R7", "no extra done", 32'(done), 32'd0);
      end
    end
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] corners [6];
    void'($urandom(32'd20240611));
    corners[0] = 32'h8000_8000;
    corners[1] = 32'hFFFF_FFFF;
    corners[2] = 32'h0000_8001;
    corners[3] = 32'h1234_ABCD;
    corners[4] = 32'h7FFF_7FFF;
    corners[5] = 32'h0000_0001;

    repeat (3) @(negedge clk);
    check(done == 1'b0, "R8", "reset done", 32'(done), 32'd0);
    check(result == 32'h0, "R8", "reset result", result, 32'h0);
    @(negedge clk);
    rst = 1'b0;

    // sweep every count 0..40 with corners and random values (R1 R2 R3 R5)
    for (int c = 0; c <= 40; c++) begin
      for (int i = 0; i < 6; i++) run_op(corners[i], 16'(c), 1'b0);
      for (int i = 0; i < 3; i++) run_op($urandom, 16'(c), 1'b0);
    end

    // large counts (R1)
    run_op(32'hDEAD_BEEF, 16'hFFFF, 1'b0);
    run_op(32'hFFFF_FFFF, 16'd32, 1'b0);
    run_op(32'h8000_0000, 16'd1000, 1'b0);

    // starts during a multiply are ignored (R7)
    run_op(32'h8765_8321, 16'd15, 1'b1);
    run_op(32'hC001_F00D, 16'd21, 1'b1);
    for (int i = 0; i < 4; i++) run_op($urandom, 16'(1 + ($urandom % 15)), 1'b1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule